// File: doc/BRIEF.md
# Floppy Boot-Sector DMA Loader

This block fills the top page of the CPU address space with boot code read from a spinning floppy disk. From reset it holds the CPU off the bus. It takes a stream of decoded disk bytes together with three framing signals: a marker at the start of each sector, a flag that says whether that sector is the last one on the track, and the drive's index pulse. It uses none of these to find a particular track or sector header. Whenever a sector marked as last-of-track goes by, its bytes are written one by one into the fixed window at the top of memory, replacing whatever the previous track left there.

The index pulse is counted so that the disk is known to be up to speed. Once the count has reached its threshold, the next last-of-track sector that is captured in full ends the load. The CPU is then released and starts running whatever that sector contained. A sector that is cut short never ends the load.

The byte input is a valid/ready stream. A byte transfers only on a cycle in which both `s_valid` and `s_ready` are high. The block lowers `s_ready` in the cycle of the final write and keeps it low from release onward, so the stream source must hold or drop its bytes during that time. There is no back-pressure from the write port: the memory must take one write on any cycle.

Top module: `disk_boot_dma`

## Requirements
- R1: Every write strobe carries an address inside the window of the top SECT_BYTES addresses: 0xFF00 to 0xFFFF with the default widths.
- R2: The write address returns to 0xFF00 at the start of each captured sector. It advances by one for each transferred byte only; cycles with `s_valid` low leave it unchanged. Data is written in arrival order, and the write strobe follows the transfer by one cycle.
- R3: No write is issued for bytes of a sector whose `sec_start` cycle had `sec_last` low. No write is issued for bytes that arrive before any captured sector starts. The byte transferred in a `sec_start` cycle is the first byte of that sector.
- R4: The track the head is on plays no part. Each complete last-of-track sector overwrites the window, so the window holds the most recent one.
- R5: Index pulses are counted on rising edges, and the count saturates at IDX_NEED (default 2). A pulse held high for several cycles counts once.
- R6: A sector qualifies for release only if the index count had already reached IDX_NEED at its `sec_start` cycle. The load ends only when the last byte of a qualifying sector is written. Until then `bus_req` stays high, including after earlier complete sectors.
- R7: If a new `sec_start` arrives before a captured sector has received all its bytes, that sector is abandoned. No release follows, and the bytes already written stay in memory.
- R8: After reset, `bus_req`=1, `done`=0, `s_ready`=1 and `dma_wr`=0. At release, `bus_req` falls and `done` rises in the same cycle, one cycle after the final write strobe.
- R9: After release, `s_ready` stays 0, no write is issued whatever the inputs do, and `done` stays 1 until reset.
- R10: `s_ready` is high exactly while loading is in progress. It is low during the cycle of the final write and from release onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Disk byte valid |
| s_ready | output | 1 | Loader accepts a disk byte |
| s_data | input | DATA_W | Decoded disk byte |
| sec_start | input | 1 | First cycle of a sector |
| sec_last | input | 1 | Sector is the last on its track (sampled with sec_start) |
| idx_pulse | input | 1 | Drive index pulse |
| dma_wr | output | 1 | Memory write strobe |
| dma_addr | output | ADDR_W | Memory write address |
| dma_data | output | DATA_W | Memory write data |
| bus_req | output | 1 | Holds the CPU off the bus while high |
| done | output | 1 | Load finished, CPU released |

## Verification
On every cycle, the assertions check four things: that each write stays inside the window, that the index count never passes its threshold, that release happens only once the count is met, and that after release the block stays silent and the done flag stays set. Only the bench's disk scenarios can show the contents that end up in memory. These are: sectors overwriting one another across tracks, a truncated sector being abandoned, a held index pulse counting once, and the final image being the last complete sector that started after the second index pulse.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_DONE = 2'd1
  } load_phase_t;
endpackage

// File: rtl/fdl_index_count.sv
module fdl_index_count #(
  parameter int IDX_NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idx_in,
  output logic idx_met
);
  localparam int CW = $clog2(IDX_NEED + 1);

  logic [CW-1:0] cnt_q;
  logic          idx_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_d <= 1'b1;   // a pulse already high at reset is not counted
    end else begin
      idx_d <= idx_in;
      if (idx_in && !idx_d && (cnt_q != CW'(IDX_NEED)))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx_met = (cnt_q == CW'(IDX_NEED));

  // R5: count saturates at the threshold
  p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(IDX_NEED));

  // R5: count only moves on a rising edge of the pulse
  p_cnt_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(idx_in) && !$past(idx_d)));
endmodule

// File: rtl/fdl_sector_capture.sv
module fdl_sector_capture #(
  parameter int DATA_W     = 8,
  parameter int SECT_BYTES = 256,
  parameter int OFF_W      = $clog2(SECT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              byte_fire,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              sec_start,
  input  logic              sec_last,
  input  logic              idx_met,
  output logic              wr,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data,
  output logic              fin
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SECT_BYTES - 1);

  logic             cap_q, qual_q;
  logic [OFF_W-1:0] off_q;

  logic             cap_now, qual_now, take, last_byte;
  logic [OFF_W-1:0] off_now;

  always_comb begin
    cap_now   = sec_start ? sec_last : cap_q;
    qual_now  = sec_start ? idx_met  : qual_q;
    off_now   = sec_start ? '0       : off_q;
    take      = enable && cap_now && byte_fire;
    last_byte = take && (off_now == LAST_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      qual_q  <= 1'b0;
      off_q   <= '0;
      wr      <= 1'b0;
      wr_off  <= '0;
      wr_data <= '0;
      fin     <= 1'b0;
    end else if (!enable) begin
      wr  <= 1'b0;
      fin <= 1'b0;
    end else begin
      cap_q  <= cap_now && !last_byte;
      qual_q <= qual_now;
      off_q  <= take ? off_now + 1'b1 : off_now;
      wr     <= take;
      fin    <= last_byte && qual_now;
      if (take) begin
        wr_off  <= off_now;
        wr_data <= byte_data;
      end
    end
  end

  // R10: a write always comes from a cycle in which loading was enabled
  p_wr_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(enable));

  // R2: the completion pulse marks the write of the top offset
  p_fin_at_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (wr && wr_off == LAST_OFF));
endmodule

// File: rtl/fdl_bus_ctrl.sv
module fdl_bus_ctrl
  import fdl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  output logic bus_req,
  output logic done
);
  load_phase_t phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      bus_req <= 1'b1;
      done    <= 1'b0;
    end else if (phase_q == PH_LOAD && fin) begin
      phase_q <= PH_DONE;
      bus_req <= 1'b0;
      done    <= 1'b1;
    end
  end

  // R8: bus request and done always change together
  p_req_done_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req != done);

  // R9: done is sticky
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/disk_boot_dma.sv
module disk_boot_dma #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SECT_BYTES = 256,
  parameter int IDX_NEED   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              sec_start,
  input  logic              sec_last,
  input  logic              idx_pulse,
  output logic              dma_wr,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [DATA_W-1:0] dma_data,
  output logic              bus_req,
  output logic              done
);
  localparam int               OFF_W    = $clog2(SECT_BYTES);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((2 ** ADDR_W) - SECT_BYTES);

  logic             idx_met, fin, loading;
  logic [OFF_W-1:0] wr_off;

  assign loading = bus_req && !fin;
  assign s_ready = loading;

  fdl_index_count #(.IDX_NEED(IDX_NEED)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_in(idx_pulse), .idx_met(idx_met)
  );

  fdl_sector_capture #(.DATA_W(DATA_W), .SECT_BYTES(SECT_BYTES), .OFF_W(OFF_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .enable(loading), .byte_fire(s_valid && s_ready),
    .byte_data(s_data), .sec_start(sec_start), .sec_last(sec_last), .idx_met(idx_met),
    .wr(dma_wr), .wr_off(wr_off), .wr_data(dma_data), .fin(fin)
  );

  fdl_bus_ctrl u_bus (
    .clk(clk), .rst_n(rst_n), .fin(fin), .bus_req(bus_req), .done(done)
  );

  assign dma_addr = WIN_BASE | ADDR_W'(wr_off);

  // R1: writes stay inside the boot window
  p_wr_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr |-> (dma_addr >= WIN_BASE));

  // R6: release never happens before the index threshold
  p_release_needs_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> idx_met);

  // R9: no memory traffic or stream acceptance once released
  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!dma_wr && !s_ready));
endmodule

// File: tb/disk_boot_dma_tb.sv
`timescale 1ns/100ps
module disk_boot_dma_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       s_valid, sec_start, sec_last, idx_pulse;
  logic [7:0] s_data;
  logic       s_ready, dma_wr, bus_req, done;
  logic [15:0] dma_addr;
  logic [7:0]  dma_data;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [15:0] first_addr, last_addr;
  logic        first_seen;

  always #2.5 clk = ~clk;

  disk_boot_dma u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .sec_start(sec_start), .sec_last(sec_last), .idx_pulse(idx_pulse),
    .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_data(dma_data),
    .bus_req(bus_req), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(((seed * 73) + (i * 11) + (i >> 3)) ^ seed);
  endfunction

  // write monitor (outputs are registered; sampled at the falling edge)
  always @(negedge clk) begin
    if (dma_wr) begin
      wr_cnt++;
      if (dma_addr < 16'hFF00) chk(0, "R1 addr", dma_addr, 16'hFF00);
      mem[dma_addr[7:0]] = dma_data;
      if (!first_seen) begin first_addr = dma_addr; first_seen = 1'b1; end
      last_addr = dma_addr;
    end
  end

  task automatic step(input bit v, input logic [7:0] d, input bit st, input bit lst, input bit ix);
    s_valid = v; s_data = d; sec_start = st; sec_last = lst; idx_pulse = ix;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 8'h00, 0, 0, 0);
  endtask

  task automatic sector(input bit lst, input int seed, input int nbytes, input bit gaps, input bit record);
    for (int i = 0; i < nbytes; i++) begin
      if (gaps && (i % 3 == 1)) step(0, 8'hA5, 0, 0, 0);
      step(1, pat(seed, i), i == 0, lst, 0);
      if (record) exp_mem[i] = pat(seed, i);
    end
  endtask

  task automatic cmp_mem(input string req);
    int bad = -1;
    #1;
    for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, mem[bad], exp_mem[bad]);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    s_valid = 0; s_data = 0; sec_start = 0; sec_last = 0; idx_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    first_seen = 1'b0;
    do_reset();
    // R8 reset state
    chk(bus_req === 1'b1, "R8 bus_req after reset", bus_req, 1);
    chk(done === 1'b0, "R8 done after reset", done, 0);
    chk(s_ready === 1'b1, "R10 s_ready after reset", s_ready, 1);
    chk(dma_wr === 1'b0, "R8 dma_wr after reset", dma_wr, 0);

    // R3: stray bytes before any sector
    for (int i = 0; i < 20; i++) step(1, 8'(i), 0, 0, 0);
    idle(2);
    chk(wr_cnt == 0, "R3 stray bytes", wr_cnt, 0);

    // Track 0: index held 4 cycles (must count once, R5)
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1);
    idle(3);
    sector(0, 1, 256, 0, 0);
    sector(0, 9, 40, 1, 0);
    idle(2);
    chk(wr_cnt == 0, "R3 non-last sectors", wr_cnt, 0);
    first_seen = 1'b0;
    sector(1, 2, 256, 1, 1);
    idle(3);
    chk(wr_cnt == 256, "R2 byte count", wr_cnt, 256);
    chk(first_addr == 16'hFF00, "R2 first addr", first_addr, 16'hFF00);
    chk(last_addr == 16'hFFFF, "R1 last addr", last_addr, 16'hFFFF);
    cmp_mem("R2 track0 image");
    chk(bus_req === 1'b1, "R5 held index counted once", bus_req, 1);
    chk(done === 1'b0, "R6 no release before threshold", done, 0);

    // Track 1: second index; last sector truncated (R7)
    step(0, 0, 0, 0, 1); idle(3);
    sector(0, 3, 256, 0, 0);
    sector(1, 4, 100, 1, 1);
    step(0, 0, 0, 0, 1); idle(2);       // next track
    sector(0, 5, 30, 0, 0);             // its sec_start abandons the partial
    idle(3);
    cmp_mem("R7 partial sector kept");
    chk(bus_req === 1'b1, "R7 no release on partial", bus_req, 1);
    chk(done === 1'b0, "R7 done low", done, 0);

    // Track 2: full qualifying last sector -> release
    wr_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      if (i % 3 == 1) step(0, 8'h5A, 0, 0, 0);
      step(1, pat(6, i), i == 0, 1, 0);
      exp_mem[i] = pat(6, i);
    end
    chk(dma_wr === 1'b1, "R8 final write strobe", dma_wr, 1);
    chk(bus_req === 1'b1, "R8 bus held during final write", bus_req, 1);
    chk(s_ready === 1'b0, "R10 s_ready low at final write", s_ready, 0);
    step(1, 8'hEE, 1, 1, 0);
    chk(bus_req === 1'b0, "R8 bus_req falls", bus_req, 0);
    chk(done === 1'b1, "R8 done rises same cycle", done, 1);
    chk(wr_cnt == 256, "R4 track2 write count", wr_cnt, 256);
    cmp_mem("R4 final image is last complete sector");

    // R9: after release nothing moves
    wr_cnt = 0;
    step(0, 0, 0, 0, 1); idle(1);
    sector(1, 7, 256, 0, 0);
    idle(3);
    chk(wr_cnt == 0, "R9 no writes after release", wr_cnt, 0);
    chk(s_ready === 1'b0, "R9 s_ready stays low", s_ready, 0);
    chk(done === 1'b1, "R9 done sticky", done, 1);
    cmp_mem("R9 memory unchanged");

    // Fresh run: two separate pulses then one sector releases (R6)
    do_reset();
    chk(bus_req === 1'b1 && done === 1'b0, "R8 state after second reset", done, 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 1); idle(2);
    sector(1, 8, 256, 0, 1);
    idle(2);
    chk(done === 1'b1, "R6 release after two index pulses", done, 1);
    cmp_mem("R4 image after second run");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule